// File: doc/BRIEF.md
# ATM Cell Label Translator

This block sits in the ingress path of a switch port. Aligned 53-byte ATM cells arrive one byte per cycle, and a start flag marks the first byte of each cell. The block collects the first four header bytes and takes the virtual path and virtual channel label from them. The label layout depends on a per-cell mode input. In user-side mode the top nibble of the header is flow-control information, and the label is an 8-bit path identifier followed by a 16-bit channel identifier. In network-side mode those four bits belong to a 12-bit path identifier.

The label is searched in a small associative table. A host writes complete entries into this table through a one-cycle write port. On a hit, the block does three things. It emits a one-byte routing tag, holding the output port number and a priority, in the cycle before the cell. It then replays the cell with the old label replaced by the new one. All other bits pass through untouched. On a miss, the cell is discarded and a miss counter advances.

Cells must be separated by at least one idle input cycle, so that the extra tag beat fits into the time slot.

Top module: `atm_label_xlate`

## Requirements
- R1: After a synchronous active-low reset, out_valid and out_tag are 0, miss_count is 0, and every table entry is invalid, so the first cell is dropped.
- R2: If header byte 0 of a cell is presented in cycle t and the lookup hits, the tag beat appears in cycle t+5 with out_tag=1. Output byte k (0..52) follows in cycle t+6+k with out_tag=0. No other output beats belong to that cell.
- R3: The tag byte carries the output port in bits [PORT_W-1:0], where PORT_W is log2 of N_PORTS, and the priority in the next PRIO_W bits. All bits above those are zero.
- R4: In network-side mode (in_nni=1), the 28-bit key is {byte0, byte1, byte2, byte3[7:4]}. On a hit, those 28 bits are replaced by the entry's new label.
- R5: In user-side mode (in_nni=0), only key bits [23:0] are compared, and only new-label bits [23:0] are written. Byte0[7:4] (flow control) leaves unchanged, and bits [27:24] of the stored old and new labels are ignored.
- R6: Byte3[3:0], byte 4 and the 48 payload bytes leave unchanged.
- R7: A cell whose label matches no valid entry produces no output beats. miss_count rises by exactly 1, and the new value is visible in cycle t+5.
- R8: A write with cfg_en=0 invalidates an entry, and an invalid entry never matches.
- R9: When several valid entries match, the entry with the lowest index supplies the new label, the port and the priority.
- R10: A host write lands in the same cycle as the lookup when it coincides with byte 3 of a cell. That lookup sees the table as it was before the write, and the write applies to later cells.
- R11: The mode is sampled with byte 0. Changing in_nni later within the cell has no effect on that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Marks byte 0 of a cell |
| in_data | input | 8 | Input cell byte |
| in_nni | input | 1 | Header mode: 1 network-side, 0 user-side; sampled with byte 0 |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_en | input | 1 | Valid bit written to the entry |
| cfg_old | input | 28 | Label to match |
| cfg_new | input | 28 | Replacement label |
| cfg_port | input | PORT_W | Output port for the tag |
| cfg_prio | input | PRIO_W | Priority for the tag |
| out_valid | output | 1 | Output beat valid |
| out_tag | output | 1 | Output beat is the routing tag |
| out_data | output | 8 | Tag byte or cell byte |
| miss_count | output | CNT_W | Number of dropped cells, wrapping |

## Verification
A host write and a label lookup can occur in the same cycle. This happens when the write coincides with header byte 3, which is the cycle in which the table is searched. The bench provokes it in two ways: it installs a matching entry exactly at byte 3, and it invalidates the matching entry exactly at byte 3. Its reference model resolves the lookup before applying the write. The cell under test must therefore be dropped in the first case and forwarded in the second, and the next cell with the same label must behave the other way. The end of one cell's output and the tag of the next can also fall close together. Cells sent with a single idle cycle between them check that the two never collide.

// File: rtl/atm_lbl_pkg.sv
// Shared constants, types and helper functions for the ATM label translator.
// Assumes cells are 53 bytes and the label ends in the high nibble of byte 3.
package atm_lbl_pkg;
    localparam int CELL_LEN     = 53;
    localparam int LBL_W        = 28;
    localparam int UNI_LBL_W    = 24;
    localparam int BIDX_W       = $clog2(CELL_LEN);
    localparam int KEY_DONE_IDX = 3;

    typedef logic [LBL_W-1:0]  label_t;
    typedef logic [BIDX_W-1:0] bidx_t;

    // Compare a stored label with a header key under the given mode.
    function automatic logic label_eq(label_t stored, label_t key, logic nni);
        if (nni) begin
            return stored == key;
        end
        return stored[UNI_LBL_W-1:0] == key[UNI_LBL_W-1:0];
    endfunction

    // Produce the outgoing version of one cell byte after label replacement.
    function automatic logic [7:0] patch_byte(bidx_t idx, logic [7:0] orig,
                                              label_t nl, logic nni);
        logic [7:0] r;
        case (idx)
            bidx_t'(0): r = nni ? nl[27:20] : {orig[7:4], nl[23:20]};
            bidx_t'(1): r = nl[19:12];
            bidx_t'(2): r = nl[11:4];
            bidx_t'(3): r = {nl[3:0], orig[3:0]};
            default:    r = orig;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/atm_hdr_parse.sv
// Header parser: numbers the bytes of each cell and holds header bytes 0..2.
// When byte 3 arrives, it presents the full 28-bit key and the per-cell mode.
// Assumes well-formed cells: byte 0 carries in_sop and bytes are contiguous.
module atm_hdr_parse
    import atm_lbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    input  logic       in_nni,
    output logic       byte_valid,
    output bidx_t      byte_idx,
    output logic [7:0] byte_data,
    output logic       lk_stb,
    output label_t     lk_key,
    output logic       lk_nni
);
    bidx_t      last_idx;
    logic [7:0] hb0, hb1, hb2;
    logic       cell_nni;

    // Position of the current byte inside its cell.
    always_comb begin
        byte_idx   = in_sop ? '0 : last_idx + 1'b1;
        byte_valid = in_valid;
        byte_data  = in_data;
    end

    // Remember the byte position, the first header bytes and the cell mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx <= '0;
            hb0      <= '0;
            hb1      <= '0;
            hb2      <= '0;
            cell_nni <= 1'b0;
        end else if (in_valid) begin
            last_idx <= byte_idx;
            case (byte_idx)
                bidx_t'(0): begin
                    hb0      <= in_data;
                    cell_nni <= in_nni;
                end
                bidx_t'(1): hb1 <= in_data;
                bidx_t'(2): hb2 <= in_data;
                default: ;
            endcase
        end
    end

    // Key is complete in the cycle byte 3 is on the input.
    always_comb begin
        lk_stb = in_valid && (byte_idx == bidx_t'(KEY_DONE_IDX));
        lk_key = {hb0, hb1, hb2, in_data[7:4]};
        lk_nni = cell_nni;
    end

    assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (byte_idx < bidx_t'(CELL_LEN)));
endmodule

// File: rtl/atm_rit_cam.sv
// Routing table: a small associative store with a one-cycle host write port.
// Searches the whole table when the key strobe is high and registers the result
// of the lowest-index match. A write in the lookup cycle is not seen by it.
module atm_rit_cam
    import atm_lbl_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int PORT_W  = 4,
    parameter  int PRIO_W  = 2,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  label_t            cfg_old,
    input  label_t            cfg_new,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              lk_stb,
    input  label_t            lk_key,
    input  logic              lk_nni,
    output logic              res_stb,
    output logic              res_hit,
    output label_t            res_new,
    output logic              res_nni,
    output logic [PORT_W-1:0] res_port,
    output logic [PRIO_W-1:0] res_prio
);
    logic [ENTRIES-1:0] ent_v;
    label_t             ent_old  [ENTRIES];
    label_t             ent_new  [ENTRIES];
    logic [PORT_W-1:0]  ent_port [ENTRIES];
    logic [PRIO_W-1:0]  ent_prio [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   sel;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_v[g] && label_eq(ent_old[g], lk_key, lk_nni);
    end

    // Lowest matching index wins.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
    end

    // Entry valid bits, cleared by reset, written whole by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) ent_v <= '0;
        else if (cfg_we) ent_v[cfg_idx] <= cfg_en;
    end

    // Entry contents, written in the same cycle as the valid bit.
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            ent_old[cfg_idx]  <= cfg_old;
            ent_new[cfg_idx]  <= cfg_new;
            ent_port[cfg_idx] <= cfg_port;
            ent_prio[cfg_idx] <= cfg_prio;
        end
    end

    // Capture the lookup outcome; it is held until the next cell's lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_stb  <= 1'b0;
            res_hit  <= 1'b0;
            res_new  <= '0;
            res_nni  <= 1'b0;
            res_port <= '0;
            res_prio <= '0;
        end else begin
            res_stb <= lk_stb;
            if (lk_stb) begin
                res_hit  <= |hit_vec;
                res_new  <= ent_new[sel];
                res_nni  <= lk_nni;
                res_port <= ent_port[sel];
                res_prio <= ent_prio[sel];
            end
        end
    end

    assert_res_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_stb |=> ($stable(res_hit) && $stable(res_new) && $stable(res_port)));
endmodule

// File: rtl/atm_cell_emit.sv
// Output stage: delays the byte stream until the lookup result is known,
// inserts the routing tag beat before byte 0 and rewrites the label bytes.
// Assumes at least one idle input cycle between cells, which leaves room for the tag.
module atm_cell_emit
    import atm_lbl_pkg::*;
#(
    parameter  int PORT_W = 4,
    parameter  int PRIO_W = 2,
    localparam int DLY    = KEY_DONE_IDX + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  bidx_t             byte_idx,
    input  logic [7:0]        byte_data,
    input  logic              res_hit,
    input  label_t            res_new,
    input  logic              res_nni,
    input  logic [PORT_W-1:0] res_port,
    input  logic [PRIO_W-1:0] res_prio,
    output logic              out_valid,
    output logic              out_tag,
    output logic [7:0]        out_data,
    output bidx_t             out_idx
);
    logic       dv [DLY];
    bidx_t      di [DLY];
    logic [7:0] dd [DLY];
    logic [7:0] tag_byte;
    logic       start_tag;
    logic [BIDX_W:0] beat_cnt;

    // Delay line valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DLY; s++) dv[s] <= 1'b0;
        end else begin
            dv[0] <= byte_valid;
            for (int s = 1; s < DLY; s++) dv[s] <= dv[s-1];
        end
    end

    // Delay line byte index and data.
    always_ff @(posedge clk) begin
        di[0] <= byte_idx;
        dd[0] <= byte_data;
        for (int s = 1; s < DLY; s++) begin
            di[s] <= di[s-1];
            dd[s] <= dd[s-1];
        end
    end

    // Tag byte and the moment it is due.
    always_comb begin
        tag_byte  = 8'({res_prio, res_port});
        start_tag = dv[DLY-2] && (di[DLY-2] == '0) && res_hit;
    end

    // Drive the tag beat or a rewritten byte; misses emit nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= 1'b0;
            out_data  <= '0;
            out_idx   <= '0;
        end else if (start_tag) begin
            out_valid <= 1'b1;
            out_tag   <= 1'b1;
            out_data  <= tag_byte;
            out_idx   <= '0;
        end else if (dv[DLY-1] && res_hit) begin
            out_valid <= 1'b1;
            out_tag   <= 1'b0;
            out_data  <= patch_byte(di[DLY-1], dd[DLY-1], res_new, res_nni);
            out_idx   <= di[DLY-1];
        end else begin
            out_valid <= 1'b0;
            out_tag   <= 1'b0;
        end
    end

    // Count the data beats since the last tag, for the length check.
    always_ff @(posedge clk) begin
        if (!rst_n) beat_cnt <= '0;
        else if (out_valid && out_tag) beat_cnt <= '0;
        else if (out_valid) beat_cnt <= beat_cnt + 1'b1;
    end

    assert_tag_then_hdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_tag |=> (out_valid && !out_tag && out_idx == '0));

    assert_cell_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_tag) |-> (beat_cnt < (BIDX_W+1)'(CELL_LEN)));
endmodule

// File: rtl/atm_label_xlate.sv
// Top of the ATM label translator: parser, routing table and output stage.
// Counts dropped cells. Input cells must have one idle cycle between them.
module atm_label_xlate
    import atm_lbl_pkg::*;
#(
    parameter  int N_PORTS = 16,
    parameter  int ENTRIES = 8,
    parameter  int PRIO_W  = 2,
    parameter  int CNT_W   = 16,
    localparam int PORT_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    input  logic              in_nni,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [27:0]       cfg_old,
    input  logic [27:0]       cfg_new,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [PRIO_W-1:0] cfg_prio,
    output logic              out_valid,
    output logic              out_tag,
    output logic [7:0]        out_data,
    output logic [CNT_W-1:0]  miss_count
);
    logic              byte_valid;
    bidx_t             byte_idx;
    logic [7:0]        byte_data;
    logic              lk_stb;
    label_t            lk_key;
    logic              lk_nni;
    logic              res_stb, res_hit, res_nni;
    label_t            res_new;
    logic [PORT_W-1:0] res_port;
    logic [PRIO_W-1:0] res_prio;
    bidx_t             emit_idx;

    atm_hdr_parse u_parse (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data), .in_nni(in_nni),
        .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
        .lk_stb(lk_stb), .lk_key(lk_key), .lk_nni(lk_nni)
    );

    atm_rit_cam #(.ENTRIES(ENTRIES), .PORT_W(PORT_W), .PRIO_W(PRIO_W)) u_cam (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_old(cfg_old), .cfg_new(cfg_new), .cfg_port(cfg_port), .cfg_prio(cfg_prio),
        .lk_stb(lk_stb), .lk_key(lk_key), .lk_nni(lk_nni),
        .res_stb(res_stb), .res_hit(res_hit), .res_new(res_new), .res_nni(res_nni),
        .res_port(res_port), .res_prio(res_prio)
    );

    atm_cell_emit #(.PORT_W(PORT_W), .PRIO_W(PRIO_W)) u_emit (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
        .res_hit(res_hit), .res_new(res_new), .res_nni(res_nni),
        .res_port(res_port), .res_prio(res_prio),
        .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data), .out_idx(emit_idx)
    );

    // Count cells dropped for lack of a matching entry.
    always_ff @(posedge clk) begin
        if (!rst_n) miss_count <= '0;
        else if (res_stb && !res_hit) miss_count <= miss_count + 1'b1;
    end

    assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + 1'b1));

    assert_drop_no_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> !out_tag);

    assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_tag && emit_idx >= bidx_t'(KEY_DONE_IDX + 1))
            |-> (out_data == $past(in_data, 6)));

    assert_gfc_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_tag && emit_idx == '0 && !res_nni)
            |-> (out_data[7:4] == $past(in_data[7:4], 6)));
endmodule

// File: tb/atm_label_xlate_tb.sv
// Bench for the ATM label translator. A behavioural reference table predicts,
// for every cycle, the output beats and the miss count, and compares them.
module atm_label_xlate_tb;
    localparam int N_PORTS = 16;
    localparam int ENTRIES = 8;
    localparam int PRIO_W  = 2;
    localparam int CNT_W   = 16;
    localparam int PORT_W  = 4;
    localparam int IDX_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_nni = 1'b0;
    logic [7:0] in_data = '0;
    logic cfg_we = 1'b0, cfg_en = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [27:0] cfg_old = '0, cfg_new = '0;
    logic [PORT_W-1:0] cfg_port = '0;
    logic [PRIO_W-1:0] cfg_prio = '0;
    logic out_valid, out_tag;
    logic [7:0] out_data;
    logic [CNT_W-1:0] miss_count;

    always #4 clk = ~clk;

    atm_label_xlate #(.N_PORTS(N_PORTS), .ENTRIES(ENTRIES), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data), .in_nni(in_nni),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_old(cfg_old),
        .cfg_new(cfg_new), .cfg_port(cfg_port), .cfg_prio(cfg_prio),
        .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data), .miss_count(miss_count)
    );

    int pc = 0;
    always @(posedge clk) pc <= pc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference table.
    bit          m_v    [ENTRIES];
    logic [27:0] m_old  [ENTRIES];
    logic [27:0] m_new  [ENTRIES];
    int          m_port [ENTRIES];
    int          m_prio [ENTRIES];

    // Expected output per cycle.
    bit         ev [int];
    bit         et [int];
    logic [7:0] ed [int];
    string      er [int];
    int         minc [int];
    int         mexp = 0;

    task automatic fail(string req, string what, longint act, longint exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, pc);
    endtask

    // Compare all outputs against the reference on every cycle.
    always @(negedge clk) begin
        bit    v;
        string r;
        if (minc.exists(pc)) mexp += minc[pc];
        v = ev.exists(pc) ? ev[pc] : 1'b0;
        r = er.exists(pc) ? er[pc] : "R1";
        checks++;
        if (out_valid !== v) fail(r, "out_valid", longint'(out_valid), longint'(v));
        if (v) begin
            checks++;
            if (out_tag !== et[pc]) fail(r, "out_tag", longint'(out_tag), longint'(et[pc]));
            checks++;
            if (out_data !== ed[pc]) fail(r, "out_data", longint'(out_data), longint'(ed[pc]));
        end
        checks++;
        if (miss_count !== CNT_W'(mexp)) fail("R7", "miss_count", longint'(miss_count), longint'(mexp));
    end

    function automatic int lookup(logic [27:0] key, bit nni);
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_v[i] && (nni ? (m_old[i] == key) : (m_old[i][23:0] == key[23:0]))) return i;
        end
        return -1;
    endfunction

    task automatic drive_cfg(int idx, bit en, logic [27:0] o, logic [27:0] n, int port, int prio);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_en = en; cfg_old = o; cfg_new = n;
        cfg_port = PORT_W'(port); cfg_prio = PRIO_W'(prio);
        m_v[idx] = en; m_old[idx] = o; m_new[idx] = n; m_port[idx] = port; m_prio[idx] = prio;
    endtask

    task automatic wr_entry(int idx, bit en, logic [27:0] o, logic [27:0] n, int port, int prio);
        @(posedge clk); #1;
        drive_cfg(idx, en, o, n, port, prio);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Send one cell; optionally change the mode after byte 0 and write an entry at byte 3.
    task automatic send_cell(logic [27:0] f, logic [3:0] low, bit nni, bit flip, int seed,
                             int gap, string req, bit wr, int widx, bit wen,
                             logic [27:0] wold, logic [27:0] wnew, int wport, int wprio);
        logic [7:0] cb [53];
        logic [27:0] nl;
        int t;
        int hit;
        cb[0] = f[27:20]; cb[1] = f[19:12]; cb[2] = f[11:4]; cb[3] = {f[3:0], low};
        cb[4] = 8'(seed) ^ 8'h5A;
        for (int k = 5; k < 53; k++) cb[k] = 8'(seed + k * 13);
        t = 0;
        for (int k = 0; k < 53; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sop = (k == 0); in_data = cb[k];
            in_nni = (k == 0) ? nni : (flip ? !nni : nni);
            if (k == 0) t = pc;
            if (k == 3) begin
                hit = lookup(f, nni);
                if (hit >= 0) begin
                    nl = m_new[hit];
                    ev[t+5] = 1'b1; et[t+5] = 1'b1; er[t+5] = req;
                    ed[t+5] = 8'((m_prio[hit] << PORT_W) | m_port[hit]);
                    for (int j = 0; j < 53; j++) begin
                        ev[t+6+j] = 1'b1; et[t+6+j] = 1'b0; er[t+6+j] = req;
                        case (j)
                            0: ed[t+6+j] = nni ? nl[27:20] : {cb[0][7:4], nl[23:20]};
                            1: ed[t+6+j] = nl[19:12];
                            2: ed[t+6+j] = nl[11:4];
                            3: ed[t+6+j] = {nl[3:0], cb[3][3:0]};
                            default: ed[t+6+j] = cb[j];
                        endcase
                    end
                end else begin
                    if (minc.exists(t+5)) minc[t+5] = minc[t+5] + 1;
                    else minc[t+5] = 1;
                    for (int j = 5; j < 59; j++) er[t+j] = req;
                end
                if (wr) drive_cfg(widx, wen, wold, wnew, wport, wprio);
            end
            if (k == 4) cfg_we = 1'b0;
        end
        for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_sop = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_v[i] = 1'b0; m_old[i] = '0; m_new[i] = '0; m_port[i] = 0; m_prio[i] = 0;
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R1: empty table drops the first cell.
        send_cell(28'h1234567, 4'h5, 1'b1, 1'b0, 3, 2, "R1", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R2 R3 R4 R6: network-side hit.
        wr_entry(0, 1'b1, 28'h1234567, 28'hABCDEF0, 5, 2);
        send_cell(28'h1234567, 4'h5, 1'b1, 1'b0, 17, 2, "R4", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R7: near-miss label.
        send_cell(28'h1234568, 4'h2, 1'b1, 1'b0, 29, 2, "R7", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R5: user-side hit, flow-control bits kept, stored upper nibbles ignored.
        wr_entry(1, 1'b1, 28'hF001357, 28'h72468AC, 9, 1);
        send_cell(28'hA001357, 4'hB, 1'b0, 1'b0, 41, 2, "R5", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R5: the same bytes in network-side mode must miss.
        send_cell(28'hA001357, 4'hB, 1'b1, 1'b0, 43, 2, "R5", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R9: two matches, lowest index wins.
        wr_entry(3, 1'b1, 28'h0C0FFEE, 28'h1111111, 3, 0);
        wr_entry(2, 1'b1, 28'h0C0FFEE, 28'h2222222, 12, 3);
        send_cell(28'h0C0FFEE, 4'h1, 1'b1, 1'b0, 55, 2, "R9", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R8: invalidate entry 2, entry 3 now supplies the label.
        wr_entry(2, 1'b0, 28'h0C0FFEE, 28'h2222222, 12, 3);
        send_cell(28'h0C0FFEE, 4'h1, 1'b1, 1'b0, 67, 2, "R8", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R10: entry installed in the lookup cycle is not seen by that cell.
        send_cell(28'h5550001, 4'h0, 1'b1, 1'b0, 71, 1, "R10", 1'b1, 4, 1'b1,
                  28'h5550001, 28'h0000ABC, 15, 1);
        // R10 R2: next cell hits, sent with a single idle cycle between cells.
        send_cell(28'h5550001, 4'h0, 1'b1, 1'b0, 73, 1, "R10", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        send_cell(28'h5550001, 4'h3, 1'b1, 1'b0, 79, 1, "R2", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R11: mode changed after byte 0 does not affect the cell.
        send_cell(28'h3001357, 4'h6, 1'b0, 1'b1, 83, 2, "R11", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        // R10: invalidation in the lookup cycle still lets this cell through.
        send_cell(28'h1234567, 4'h5, 1'b1, 1'b0, 89, 2, "R10", 1'b1, 0, 1'b0,
                  28'h1234567, 28'hABCDEF0, 5, 2);
        // R8: the now-invalid entry no longer matches.
        send_cell(28'h1234567, 4'h5, 1'b1, 1'b0, 97, 2, "R8", 1'b0, 0, 1'b0, '0, '0, 0, 0);
        repeat (70) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule